// File: doc/BRIEF.md
# Attribute-Caching Translation Buffer with Large-Page Splitting

This block is a small fully associative translation buffer that keeps, next to each virtual-to-physical mapping, the memory attributes and protection bits that apply to that range. A lookup presents a virtual address, and one cycle later the block answers with hit or miss, the physical address and the cached attribute byte. An external walker and attribute checker resolve misses and write the result through the fill port.

Attribute regions may be as small as 4 KiB, so a 2 MiB or 1 GiB mapping can cover regions with different attributes. The block never caches such a page as one entry. A large fill flagged non-uniform is stored as a single 4 KiB entry covering only the faulting granule. A large uniform entry can carry a 16-bit subregion mask, so that holes in it fall through to small entries. A fill flagged as finer than a page is not cached at all, so every access to it misses and is checked again. A flush input empties the buffer when protection settings change.

The response stage is a three-state machine. RSP_IDLE means no answer this cycle. RSP_HIT means a matching entry was found. RSP_MISS means a lookup found nothing or was killed by a flush. From any state the machine moves to RSP_HIT on a lookup that matches while no flush is present. It moves to RSP_MISS on a lookup that does not match or that coincides with a flush. It moves to RSP_IDLE when there is no lookup.

Top module: `attr_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low, and any lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: A 4 KiB entry hits when all 27 VPN bits (VA[38:12]) match. It returns PA = {PPN, VA[11:0]} and its attribute byte. On a miss, `rsp_pa` and `rsp_attr` are zero.
- R4: Size code 1 is a 2 MiB page and compares VA[38:21]. Size code 2 is a 1 GiB page and compares VA[38:30]. In both cases the low VA bits below the page boundary pass through into the PA.
- R5: A large entry only hits if the mask bit selected by the subregion index is set. The index is VA[20:17] for 2 MiB pages and VA[29:26] for 1 GiB pages. Otherwise the access misses on that entry.
- R6: A fill with size code 1 or 2 and `fill_uniform` low installs one 4 KiB entry for `fill_vpn` only. Its PPN is the page base PPN with the granule bits of `fill_vpn` inserted. Other granules of that page miss.
- R7: A fill with `fill_nocache` high writes no entry, so lookups to that address keep missing.
- R8: When entries of different sizes match, the smallest page size supplies the result.
- R9: A lookup in the same cycle as `flush` returns a miss. Every entry is invalid from the next cycle on, and a fill in the flush cycle is dropped.
- R10: Installs replace entries in round-robin order starting at entry 0. With 8 entries, the ninth install overwrites the first one installed.
- R11: A lookup in the same cycle as a fill sees the contents before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 39 | Lookup virtual address |
| fill_valid | input | 1 | Fill request from walker |
| fill_vpn | input | 27 | VPN of the faulting access |
| fill_ppn | input | 28 | PPN of the page (base for large pages) |
| fill_size | input | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fill_attr | input | 8 | Attribute and protection byte |
| fill_mask | input | 16 | Subregion present mask for large pages |
| fill_uniform | input | 1 | Attributes uniform across the whole page |
| fill_nocache | input | 1 | Region finer than a page; do not cache |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_pa | output | 40 | Translated physical address |
| rsp_attr | output | 8 | Cached attribute byte |

## Verification
Two pairs of events can land in the same cycle: a lookup with a flush, and a fill with either a flush or a lookup. The bench drives `flush` and `lk_valid` on the same falling edge, for an address that hit just before. It expects a miss answer in the next cycle and misses on every later lookup. It also raises `fill_valid` together with `flush`, and together with a lookup of the address being filled. In the first case the mapping must stay absent afterwards. In the second case the concurrent lookup must miss while the following lookup hits.

// File: rtl/attr_tlb_pkg.sv
package attr_tlb_pkg;
    localparam int unsigned VA_W   = 39;
    localparam int unsigned PA_W   = 40;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned VPN_W  = VA_W - OFF_W;
    localparam int unsigned PPN_W  = PA_W - OFF_W;
    localparam int unsigned LVL_W  = 9;
    localparam int unsigned ATTR_W = 8;
    localparam int unsigned SUB_N  = 16;
    localparam int unsigned SUB_W  = $clog2(SUB_N);

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        pg_size_e          size;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
        logic [SUB_N-1:0]  mask;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/attr_tlb_entry.sv
module attr_tlb_entry
    import attr_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  tlb_ent_t          wr_data,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              valid_o,
    output logic              hit_o,
    output pg_size_e          size_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [ATTR_W-1:0] attr_o
);
    localparam int unsigned HI2 = LVL_W;
    localparam int unsigned HI1 = 2 * LVL_W;

    tlb_ent_t ent;
    logic     tag_eq;
    logic     sub_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent <= '0;
        end else if (flush) begin
            ent.valid <= 1'b0;
        end else if (wr_en) begin
            ent <= wr_data;
        end
    end

    always_comb begin
        tag_eq = 1'b0;
        sub_ok = 1'b1;
        ppn_o  = ent.ppn;
        unique case (ent.size)
            PG_4K: begin
                tag_eq = (ent.vpn == lk_vpn);
            end
            PG_2M: begin
                tag_eq = (ent.vpn[VPN_W-1:HI2] == lk_vpn[VPN_W-1:HI2]);
                sub_ok = ent.mask[lk_vpn[HI2-1 -: SUB_W]];
                ppn_o  = {ent.ppn[PPN_W-1:HI2], lk_vpn[HI2-1:0]};
            end
            PG_1G: begin
                tag_eq = (ent.vpn[VPN_W-1:HI1] == lk_vpn[VPN_W-1:HI1]);
                sub_ok = ent.mask[lk_vpn[HI1-1 -: SUB_W]];
                ppn_o  = {ent.ppn[PPN_W-1:HI1], lk_vpn[HI1-1:0]};
            end
            default: begin
                tag_eq = 1'b0;
            end
        endcase
    end

    assign valid_o = ent.valid;
    assign hit_o   = ent.valid && tag_eq && sub_ok;
    assign size_o  = ent.size;
    assign attr_o  = ent.attr;
endmodule

// File: rtl/attr_tlb_select.sv
module attr_tlb_select
    import attr_tlb_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]      hit_i,
    input  pg_size_e          size_i [N],
    input  logic [PPN_W-1:0]  ppn_i  [N],
    input  logic [ATTR_W-1:0] attr_i [N],
    output logic              any_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [ATTR_W-1:0] attr_o
);
    localparam int unsigned N_SIZES = 3;

    always_comb begin
        any_o  = 1'b0;
        ppn_o  = '0;
        attr_o = '0;
        for (int s = 0; s < N_SIZES; s++) begin
            for (int i = 0; i < N; i++) begin
                if (!any_o && hit_i[i] && (size_i[i] == pg_size_e'(2'(s)))) begin
                    any_o  = 1'b1;
                    ppn_o  = ppn_i[i];
                    attr_o = attr_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/attr_tlb_victim.sv
module attr_tlb_victim #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (advance) begin
            idx_o <= (idx_o == LAST) ? '0 : idx_o + 1'b1;
        end
    end
endmodule

// File: rtl/attr_tlb.sv
module attr_tlb
    import attr_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [1:0]        fill_size,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic [SUB_N-1:0]  fill_mask,
    input  logic              fill_uniform,
    input  logic              fill_nocache,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr
);
    localparam int unsigned HI2 = LVL_W;
    localparam int unsigned HI1 = 2 * LVL_W;

    logic [VPN_W-1:0]  lk_vpn;
    logic              install;
    logic              split;
    pg_size_e          req_size;
    tlb_ent_t          wr_data;
    logic [IDX_W-1:0]  victim_idx;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_hit;
    pg_size_e           ent_size [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
    logic [ATTR_W-1:0]  ent_attr [ENTRIES];

    logic              any_hit;
    logic [PPN_W-1:0]  sel_ppn;
    logic [ATTR_W-1:0] sel_attr;

    rsp_state_e        state_q, state_d;
    logic [PA_W-1:0]   pa_q;
    logic [ATTR_W-1:0] attr_q;

    assign lk_vpn   = lk_va[VA_W-1:OFF_W];
    assign req_size = pg_size_e'(fill_size);
    assign install  = fill_valid && !flush && !fill_nocache;
    assign split    = (req_size != PG_4K) && !fill_uniform;

    always_comb begin
        wr_data       = '0;
        wr_data.valid = 1'b1;
        wr_data.vpn   = fill_vpn;
        wr_data.attr  = fill_attr;
        wr_data.mask  = fill_mask;
        wr_data.size  = split ? PG_4K : req_size;
        wr_data.ppn   = fill_ppn;
        if (split) begin
            if (req_size == PG_2M) begin
                wr_data.ppn = {fill_ppn[PPN_W-1:HI2], fill_vpn[HI2-1:0]};
            end else begin
                wr_data.ppn = {fill_ppn[PPN_W-1:HI1], fill_vpn[HI1-1:0]};
            end
        end
    end

    attr_tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (install),
        .idx_o   (victim_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        attr_tlb_entry u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wr_en   (install && (victim_idx == IDX_W'(g))),
            .wr_data (wr_data),
            .lk_vpn  (lk_vpn),
            .valid_o (ent_valid[g]),
            .hit_o   (ent_hit[g]),
            .size_o  (ent_size[g]),
            .ppn_o   (ent_ppn[g]),
            .attr_o  (ent_attr[g])
        );
    end

    attr_tlb_select #(.N(ENTRIES)) u_select (
        .hit_i  (ent_hit),
        .size_i (ent_size),
        .ppn_i  (ent_ppn),
        .attr_i (ent_attr),
        .any_o  (any_hit),
        .ppn_o  (sel_ppn),
        .attr_o (sel_attr)
    );

    always_comb begin
        state_d = RSP_IDLE;
        if (lk_valid) begin
            state_d = (any_hit && !flush) ? RSP_HIT : RSP_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            pa_q    <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RSP_HIT) begin
                pa_q   <= {sel_ppn, lk_va[OFF_W-1:0]};
                attr_q <= sel_attr;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_pa    = '0;
        rsp_attr  = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
            end
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_pa    = pa_q;
                rsp_attr  = attr_q;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/attr_tlb_chk.sv
module attr_tlb_chk #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             flush,
    input logic             fill_valid,
    input logic             fill_nocache,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [N-1:0]     ent_valid,
    input logic [IDX_W-1:0] victim
);
    logic install;
    assign install = fill_valid && !fill_nocache && !flush;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    assert_rsp_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    assert_hit_is_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    assert_flush_kills_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_valid) |=> (rsp_valid && !rsp_hit));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    assert_nocache_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_nocache && !flush) |=> $stable(ent_valid));

    assert_install_at_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> ent_valid[$past(victim)]);

    assert_victim_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (install && (N > 1)) |=> (victim != $past(victim)));
endmodule

bind attr_tlb attr_tlb_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_attr_tlb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .flush        (flush),
    .fill_valid   (fill_valid),
    .fill_nocache (fill_nocache),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .ent_valid    (ent_valid),
    .victim       (victim_idx)
);

// File: tb/test_attr_tlb.sv
`timescale 1ns/1ps
module test_attr_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [38:0] lk_va = '0;
    logic        fill_valid = 1'b0;
    logic [26:0] fill_vpn = '0;
    logic [27:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic [7:0]  fill_attr = '0;
    logic [15:0] fill_mask = '0;
    logic        fill_uniform = 1'b1;
    logic        fill_nocache = 1'b0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [39:0] rsp_pa;
    logic [7:0]  rsp_attr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    attr_tlb i_attr_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_size(fill_size), .fill_attr(fill_attr), .fill_mask(fill_mask),
        .fill_uniform(fill_uniform), .fill_nocache(fill_nocache), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr)
    );

    typedef struct packed {
        logic [38:0] va;
        logic        hit;
        logic [39:0] pa;
        logic [7:0]  attr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{39'h0000001234, 1'b1, 40'h00000AB234, 8'h11, 4'd3},  // R3 4 KiB hit
        '{39'h0000612345, 1'b1, 40'h0001212345, 8'h22, 4'd4},  // R4 2 MiB
        '{39'h0000640000, 1'b1, 40'h0001240000, 8'h22, 4'd5},  // R5 mask bit set
        '{39'h0000660010, 1'b0, 40'h0,          8'h00, 4'd5},  // R5 mask hole
        '{39'h004ABCDEF0, 1'b1, 40'h008ABCDEF0, 8'h33, 4'd4},  // R4 1 GiB
        '{39'h0040005678, 1'b1, 40'h0000077678, 8'h44, 4'd8},  // R8 small wins
        '{39'h0000A03ABC, 1'b1, 40'h0003403ABC, 8'h55, 4'd6},  // R6 split granule
        '{39'h0000A04000, 1'b0, 40'h0,          8'h00, 4'd6},  // R6 neighbour misses
        '{39'h0000002000, 1'b0, 40'h0,          8'h00, 4'd7},  // R7 not cached
        '{39'h0010000000, 1'b0, 40'h0,          8'h00, 4'd3}   // R3 unmapped
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [38:0] va);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_va    = va;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic hit, input logic [39:0] pa,
                              input logic [7:0] attr);
        check(tag, {14'd0, rsp_valid, rsp_hit, rsp_pa, rsp_attr},
                   {14'd0, 1'b1, hit, pa, attr});
    endtask

    task automatic fill(input logic [26:0] vpn, input logic [27:0] ppn, input logic [1:0] sz,
                        input logic [7:0] attr, input logic uni, input logic nc,
                        input logic [15:0] mask);
        @(negedge clk);
        fill_valid   = 1'b1;
        fill_vpn     = vpn;
        fill_ppn     = ppn;
        fill_size    = sz;
        fill_attr    = attr;
        fill_uniform = uni;
        fill_nocache = nc;
        fill_mask    = mask;
        @(negedge clk);
        fill_valid   = 1'b0;
        fill_nocache = 1'b0;
        fill_uniform = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, lookup misses
        check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        lookup(39'h0000001234);
        expect_rsp("R1 empty lookup", 1'b0, 40'h0, 8'h0);

        fill(27'h0040000, 28'h0080000, 2'd2, 8'h33, 1'b1, 1'b0, 16'hFFFF); // idx0
        fill(27'h0000001, 28'h00000AB, 2'd0, 8'h11, 1'b1, 1'b0, 16'h0000); // idx1
        fill(27'h0000600, 28'h0001200, 2'd1, 8'h22, 1'b1, 1'b0, 16'hFFF7); // idx2
        fill(27'h0040005, 28'h0000077, 2'd0, 8'h44, 1'b1, 1'b0, 16'h0000); // idx3
        fill(27'h0000A03, 28'h0003400, 2'd1, 8'h55, 1'b0, 1'b0, 16'hFFFF); // idx4 split
        fill(27'h0000002, 28'h0000099, 2'd0, 8'h66, 1'b1, 1'b1, 16'h0000); // not cached

        for (int k = 0; k < NV; k++) begin
            lookup(VEC[k].va);
            expect_rsp($sformatf("R%0d vector %0d", VEC[k].req, k),
                       VEC[k].hit, VEC[k].pa, VEC[k].attr);
        end

        // R2: no answer in a cycle after an idle cycle
        @(negedge clk);
        check("R2 idle rsp_valid", {63'd0, rsp_valid}, 64'd0);

        // R11: fill and lookup of the same address in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 27'h3; fill_ppn = 28'h33; fill_size = 2'd0;
        fill_attr = 8'h77; fill_mask = '0; fill_uniform = 1'b1; fill_nocache = 1'b0;
        lk_valid = 1'b1; lk_va = 39'h0000003010;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        expect_rsp("R11 concurrent lookup sees old", 1'b0, 40'h0, 8'h0);
        lookup(39'h0000003010);
        expect_rsp("R11 later lookup hits", 1'b1, 40'h0000033010, 8'h77);  // idx5

        // R10: three more installs, the last wraps to entry 0
        fill(27'h10, 28'h10, 2'd0, 8'h81, 1'b1, 1'b0, 16'h0);  // idx6
        fill(27'h11, 28'h11, 2'd0, 8'h82, 1'b1, 1'b0, 16'h0);  // idx7
        fill(27'h12, 28'h12, 2'd0, 8'h83, 1'b1, 1'b0, 16'h0);  // idx0
        lookup(39'h004ABCDEF0);
        expect_rsp("R10 oldest evicted", 1'b0, 40'h0, 8'h0);
        lookup(39'h0000001234);
        expect_rsp("R10 second kept", 1'b1, 40'h00000AB234, 8'h11);
        lookup(39'h0000012FFF);
        expect_rsp("R10 new entry", 1'b1, 40'h0000012FFF, 8'h83);

        // R9: flush together with lookup and fill
        @(negedge clk);
        flush = 1'b1; lk_valid = 1'b1; lk_va = 39'h0000612345;
        fill_valid = 1'b1; fill_vpn = 27'h20; fill_ppn = 28'h20; fill_size = 2'd0;
        fill_attr = 8'h90;
        @(negedge clk);
        flush = 1'b0; lk_valid = 1'b0; fill_valid = 1'b0;
        expect_rsp("R9 lookup during flush", 1'b0, 40'h0, 8'h0);
        lookup(39'h0000612345);
        expect_rsp("R9 flushed large entry", 1'b0, 40'h0, 8'h0);
        lookup(39'h0000001234);
        expect_rsp("R9 flushed small entry", 1'b0, 40'h0, 8'h0);
        lookup(39'h0000020000);
        expect_rsp("R9 fill dropped by flush", 1'b0, 40'h0, 8'h0);

        finish_run();
    end
endmodule